// File: doc/BRIEF.md
# Flash Erase Command Sequencer

This block is the device-side command logic of a parallel NOR-style flash write interface, reduced to its erase path. A host issues single-cycle bus writes (strobe, word address, byte of data). The block recognises two six-write command sequences, whole-array erase and sector erase, and runs a modelled erase on a small register array. Each erase first forces every selected word to 00h and then sets it to FFh. Reads are accepted at any time and return the addressed word one cycle later, so the host can watch the array pass through its intermediate state.

A sector erase does not start at once. The final write of the sequence opens an acceptance window of `T_TOW` clock cycles. While the window is open, a bare 30h write, with no unlock writes, adds one more sector and restarts the window. The erase starts when the window runs out with no new write. Queued sectors are then handled one at a time in ascending index order. Each one takes `T_PROG` cycles of zero-programming followed by `T_ERASE` cycles of erasing. When the last one is finished, the block returns to read mode by itself.

Top module: `erase_cmd_seq`

## Requirements
- R1: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a whole-array erase. `busy` goes high on the clock edge that samples the last write and stays high for NSECT*(T_PROG+T_ERASE) cycles. Afterwards every word reads FFh.
- R2: If the sixth write carries 30h, the sector is named by any address in it. The sector is addr[4:3] and the word is addr[2:0] under the default parameters, and higher address bits are ignored. At the end of the erase every word of that sector reads FFh.
- R3: A write whose address or data does not match the expected next step returns the decoder to read mode. A broken sequence never starts an erase, and it leaves the array unchanged.
- R4: After the last accepted 30h write, `busy` rises exactly T_TOW cycles later, provided no other write arrives in the meantime.
- R5: While the window is open, each 30h write, with no unlock writes, adds its sector and reloads the window to T_TOW. This also applies to a write that lands on the cycle the window would have expired. The total busy time is (number of queued sectors)*(T_PROG+T_ERASE).
- R6: Queued sectors are processed in ascending index order. A sector reads 00h once its first T_PROG busy cycles have passed. Sectors later in the queue still hold their old contents at that point.
- R7: Sectors that are not queued keep their contents across the erase.
- R8: While the window is open, any write other than 30h (F0h in particular) empties the queue, closes the window and returns to read mode. A following bare 30h write starts nothing.
- R9: Writes received while `busy` is high are ignored. A complete sector sequence sent during an erase neither opens a window nor starts a second erase.
- R10: `rdata` is loaded with the addressed word on each edge where `rd_en` is high, and is held otherwise. Once the erase has finished, the block accepts new command sequences.
- R11: After reset, `busy` is 0, `rdata` is 00h, and array word w holds (3*w+1) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 8 | Write data / command byte |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | High while an erase is running |

## Verification
The window timer expiring and a new 30h write arriving can fall on the same clock edge. In that case the write must win: it queues its sector and reloads the window, so no erase starts on that edge. The bench provokes this by timing a third sector write to land on exactly the T_TOW-th edge after the previous one. It then checks that `busy` stayed low up to that point, that it rises a full T_TOW cycles after the late write, and that the busy period covers all three sectors. An every-cycle comparison against a behavioural model also judges a read that samples a word on the same edge that clears it: the read must return the value from before the clear.

// File: rtl/efs_pkg.sv
package efs_pkg;
  typedef enum logic [2:0] {
    DS_IDLE, DS_UNL1, DS_UNL2, DS_SETUP, DS_UNL4, DS_CMD
  } dec_state_e;

  localparam logic [7:0] CODE_UNL_A = 8'hAA;
  localparam logic [7:0] CODE_UNL_B = 8'h55;
  localparam logic [7:0] CODE_SETUP = 8'h80;
  localparam logic [7:0] CODE_CHIP  = 8'h10;
  localparam logic [7:0] CODE_SECT  = 8'h30;
  localparam int unsigned KEY_ADDR_A = 32'h555;
  localparam int unsigned KEY_ADDR_B = 32'h2AA;
endpackage

// File: rtl/efs_decoder.sv
module efs_decoder
  import efs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              win_open,
  output logic              add_sector,
  output logic              start_chip,
  output logic              abort_win
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(KEY_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(KEY_ADDR_B);

  dec_state_e st_q, st_d;
  logic at_a, at_b;

  assign at_a = (addr == ADR_A);
  assign at_b = (addr == ADR_B);

  always_comb begin
    st_d       = st_q;
    add_sector = 1'b0;
    start_chip = 1'b0;
    abort_win  = 1'b0;
    if (wr_en && !busy) begin
      st_d = DS_IDLE;
      if (win_open) begin
        if (wdata == CODE_SECT) add_sector = 1'b1;
        else                    abort_win  = 1'b1;
      end else begin
        case (st_q)
          DS_IDLE:  if (at_a && wdata == CODE_UNL_A) st_d = DS_UNL1;
          DS_UNL1:  if (at_b && wdata == CODE_UNL_B) st_d = DS_UNL2;
          DS_UNL2:  if (at_a && wdata == CODE_SETUP) st_d = DS_SETUP;
          DS_SETUP: if (at_a && wdata == CODE_UNL_A) st_d = DS_UNL4;
          DS_UNL4:  if (at_b && wdata == CODE_UNL_B) st_d = DS_CMD;
          DS_CMD: begin
            if (at_a && wdata == CODE_CHIP) start_chip = 1'b1;
            else if (wdata == CODE_SECT)    add_sector = 1'b1;
          end
          default: st_d = DS_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DS_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/efs_window.sv
module efs_window #(
  parameter  int NSECT = 4,
  parameter  int T_TOW = 20,
  localparam int SEC_W = $clog2(NSECT),
  localparam int TW    = $clog2(T_TOW + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_sector,
  input  logic             abort_win,
  input  logic [SEC_W-1:0] add_sec,
  output logic             win_open,
  output logic             launch,
  output logic [NSECT-1:0] sel_mask
);
  logic             open_q, open_d;
  logic [TW-1:0]    timer_q, timer_d;
  logic [NSECT-1:0] mask_q, mask_d;

  always_comb begin
    open_d  = open_q;
    timer_d = timer_q;
    mask_d  = mask_q;
    launch  = 1'b0;
    if (add_sector) begin
      mask_d  = mask_q | (NSECT'(1) << add_sec);
      timer_d = TW'(T_TOW);
      open_d  = 1'b1;
    end else if (abort_win) begin
      mask_d  = '0;
      timer_d = '0;
      open_d  = 1'b0;
    end else if (open_q) begin
      if (timer_q == TW'(1)) begin
        launch = 1'b1;
        open_d = 1'b0;
        mask_d = '0;
      end
      timer_d = timer_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      timer_q <= '0;
      mask_q  <= '0;
    end else begin
      open_q  <= open_d;
      timer_q <= timer_d;
      mask_q  <= mask_d;
    end
  end

  assign win_open = open_q;
  assign sel_mask = mask_q;
endmodule

// File: rtl/efs_engine.sv
module efs_engine #(
  parameter  int NSECT   = 4,
  parameter  int T_PROG  = 6,
  parameter  int T_ERASE = 10,
  localparam int SEC_W   = $clog2(NSECT),
  localparam int CW      = $clog2((T_PROG > T_ERASE ? T_PROG : T_ERASE) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [NSECT-1:0] launch_mask,
  input  logic             chip_start,
  output logic             busy,
  output logic             op_zero,
  output logic             op_fill,
  output logic [SEC_W-1:0] op_sec
);
  logic             busy_q, busy_d;
  logic             phase_q, phase_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [NSECT-1:0] rem_q, rem_d;
  logic [SEC_W-1:0] cur;

  always_comb begin
    cur = '0;
    for (int i = NSECT - 1; i >= 0; i--) begin
      if (rem_q[i]) cur = SEC_W'(i);
    end
  end

  always_comb begin
    busy_d  = busy_q;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    op_zero = 1'b0;
    op_fill = 1'b0;
    if (chip_start || launch) begin
      busy_d  = 1'b1;
      rem_d   = chip_start ? {NSECT{1'b1}} : launch_mask;
      phase_d = 1'b0;
      cnt_d   = '0;
    end else if (busy_q) begin
      if (!phase_q) begin
        if (cnt_q == CW'(T_PROG - 1)) begin
          op_zero = 1'b1;
          phase_d = 1'b1;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end else if (cnt_q == CW'(T_ERASE - 1)) begin
        op_fill = 1'b1;
        rem_d   = rem_q & ~(NSECT'(1) << cur);
        phase_d = 1'b0;
        cnt_d   = '0;
        busy_d  = |rem_d;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
      rem_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
    end
  end

  assign busy   = busy_q;
  assign op_sec = cur;
endmodule

// File: rtl/efs_array.sv
module efs_array #(
  parameter  int NSECT = 4,
  parameter  int WPS   = 8,
  localparam int WORDS = NSECT * WPS,
  localparam int IDX_W = $clog2(WORDS),
  localparam int SEC_W = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             op_zero,
  input  logic             op_fill,
  input  logic [SEC_W-1:0] op_sec,
  output logic [7:0]       rdata
);
  logic [7:0] cells [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [SEC_W-1:0] MY_SEC = SEC_W'(w / WPS);
    localparam logic [7:0]       INIT   = 8'((w * 3 + 1) % 256);
    logic       hit;
    logic [7:0] cell_q;

    assign hit = (op_sec == MY_SEC);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cell_q <= INIT;
      else if (hit && op_fill)   cell_q <= 8'hFF;
      else if (hit && op_zero)   cell_q <= 8'h00;
    end

    assign cells[w] = cell_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= 8'h00;
    else if (rd_en) rdata <= cells[rd_idx];
  end
endmodule

// File: rtl/erase_cmd_seq.sv
module erase_cmd_seq #(
  parameter int ADDR_W  = 12,
  parameter int NSECT   = 4,
  parameter int WPS     = 8,
  parameter int T_TOW   = 20,
  parameter int T_PROG  = 6,
  parameter int T_ERASE = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int SEC_W = $clog2(NSECT);
  localparam int WB_W  = $clog2(WPS);
  localparam int IDX_W = SEC_W + WB_W;

  logic             add_sector, start_chip, abort_win;
  logic             win_open, launch;
  logic [NSECT-1:0] sel_mask;
  logic             op_zero, op_fill;
  logic [SEC_W-1:0] op_sec;
  logic [SEC_W-1:0] addr_sec;

  assign addr_sec = addr[IDX_W-1:WB_W];

  efs_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .busy(busy), .win_open(win_open), .add_sector(add_sector),
    .start_chip(start_chip), .abort_win(abort_win)
  );

  efs_window #(.NSECT(NSECT), .T_TOW(T_TOW)) u_win (
    .clk(clk), .rst_n(rst_n), .add_sector(add_sector), .abort_win(abort_win),
    .add_sec(addr_sec), .win_open(win_open), .launch(launch), .sel_mask(sel_mask)
  );

  efs_engine #(.NSECT(NSECT), .T_PROG(T_PROG), .T_ERASE(T_ERASE)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_mask(sel_mask),
    .chip_start(start_chip), .busy(busy), .op_zero(op_zero),
    .op_fill(op_fill), .op_sec(op_sec)
  );

  efs_array #(.NSECT(NSECT), .WPS(WPS)) u_arr (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(addr[IDX_W-1:0]),
    .op_zero(op_zero), .op_fill(op_fill), .op_sec(op_sec), .rdata(rdata)
  );
endmodule

// File: rtl/efs_chk.sv
module efs_chk #(
  parameter int NSECT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             busy,
  input logic             win_open,
  input logic             add_sector,
  input logic             start_chip,
  input logic             abort_win,
  input logic             launch,
  input logic [NSECT-1:0] sel_mask
);
  // R1: a whole-array command makes the erase busy on the next cycle, with no window
  a_r1_chip_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_chip |=> (busy && !win_open));

  // R4: window expiry hands over to the erase engine
  a_r4_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R5: a queued sector always leaves the window open
  a_r5_add_opens: assert property (@(posedge clk) disable iff (!rst_n)
    add_sector |=> (win_open && sel_mask != '0));

  // R8: abort empties the queue and closes the window
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_win |=> (!win_open && sel_mask == '0));

  // R9: window and erase never overlap
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && win_open));

  // R9: a write during an erase cannot open a window
  a_r9_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> !win_open);
endmodule

bind erase_cmd_seq efs_chk #(.NSECT(NSECT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .win_open(win_open),
  .add_sector(add_sector), .start_chip(start_chip), .abort_win(abort_win),
  .launch(launch), .sel_mask(sel_mask)
);

// File: tb/tb_erase_cmd_seq.sv
`timescale 1ns/1ps
module tb_erase_cmd_seq;
  localparam int NS = 4, WPS = 8, WORDS = NS * WPS;
  localparam int TT = 20, TP = 6, TE = 10;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy;

  erase_cmd_seq #(.ADDR_W(12), .NSECT(NS), .WPS(WPS), .T_TOW(TT),
                  .T_PROG(TP), .T_ERASE(TE)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int init_val(input int w);
    return (w * 3 + 1) % 256;
  endfunction

  // behavioural reference model
  int         m_mem [WORDS];
  int         m_rdata, m_timer, m_dst, m_phase, m_cnt;
  bit         m_busy, m_win;
  bit [NS-1:0] m_mask;
  int         m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) m_mem[w] = init_val(w);
      m_rdata = 0; m_busy = 0; m_win = 0; m_timer = 0; m_dst = 0;
      m_mask = '0; m_q.delete(); m_phase = 0; m_cnt = 0;
    end else begin
      int idx, sec;
      idx = int'(addr) % WORDS;
      sec = idx / WPS;
      if (rd_en) m_rdata = m_mem[idx];
      if (m_busy) begin
        m_cnt++;
        if (m_phase == 0 && m_cnt == TP) begin
          for (int w = 0; w < WPS; w++) m_mem[m_q[0] * WPS + w] = 0;
          m_phase = 1; m_cnt = 0;
        end else if (m_phase == 1 && m_cnt == TE) begin
          for (int w = 0; w < WPS; w++) m_mem[m_q[0] * WPS + w] = 255;
          void'(m_q.pop_front());
          m_phase = 0; m_cnt = 0;
          if (m_q.size() == 0) m_busy = 0;
        end
      end else if (m_win) begin
        if (wr_en) begin
          if (wdata == 8'h30) begin m_mask[sec] = 1'b1; m_timer = TT; end
          else begin m_mask = '0; m_win = 0; end
        end else if (m_timer == 1) begin
          m_win = 0;
          for (int s = 0; s < NS; s++) if (m_mask[s]) m_q.push_back(s);
          m_mask = '0; m_busy = 1; m_phase = 0; m_cnt = 0;
        end else m_timer--;
      end else if (wr_en) begin
        case (m_dst)
          0: m_dst = (addr == 12'h555 && wdata == 8'hAA) ? 1 : 0;
          1: m_dst = (addr == 12'h2AA && wdata == 8'h55) ? 2 : 0;
          2: m_dst = (addr == 12'h555 && wdata == 8'h80) ? 3 : 0;
          3: m_dst = (addr == 12'h555 && wdata == 8'hAA) ? 4 : 0;
          4: m_dst = (addr == 12'h2AA && wdata == 8'h55) ? 5 : 0;
          default: begin
            m_dst = 0;
            if (addr == 12'h555 && wdata == 8'h10) begin
              for (int s = 0; s < NS; s++) m_q.push_back(s);
              m_busy = 1; m_phase = 0; m_cnt = 0;
            end else if (wdata == 8'h30) begin
              m_win = 1; m_mask[sec] = 1'b1; m_timer = TT;
            end
          end
        endcase
      end
    end
  end

  // every-cycle comparison and busy monitors
  int run = 0, last_run = 0;
  bit saw_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(rdata == 8'(m_rdata), "R10 rdata vs model", int'(rdata), m_rdata);
      check(busy == m_busy, "R4 busy vs model", int'(busy), int'(m_busy));
    end
    if (busy) begin run++; saw_busy = 1; end
    else if (run != 0) begin last_run = run; run = 0; end
  end

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output int v);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic unlock5();
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h555, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (!busy && n < 500) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 2000) begin @(negedge clk); g++; end
    idle(2);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(200000 * 5.0);
    $display("FAIL watchdog expired actual=0 expected=1");
    checks++; errors++;
    summary();
    $finish;
  end

  initial begin
    int v, n;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R11 reset state
    check(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
    check(rdata == 8'h00, "R11 rdata after reset", int'(rdata), 0);
    rd(12'h005, v);
    check(v == init_val(5), "R11 initial word 5", v, init_val(5));

    // R3 broken sequence
    do_reset(); saw_busy = 0;
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h123, 8'h80);
    wr(12'h555, 8'hAA); wr(12'h2AA, 8'h55); wr(12'h008, 8'h30);
    idle(TT + 10);
    check(!saw_busy, "R3 broken sequence started erase", int'(saw_busy), 0);
    rd(12'h008, v);
    check(v == init_val(8), "R3 word 8 unchanged", v, init_val(8));

    // R2/R4/R6/R7 single sector via high-bit alias
    do_reset();
    unlock5();
    wr(12'h40B, 8'h30);
    wait_busy(n);
    check(n == TT, "R4 window length", n, TT);
    rd(12'h00B, v);
    check(v == init_val(11), "R6 old data before preprogram", v, init_val(11));
    idle(TP - 1);
    rd(12'h00B, v);
    check(v == 0, "R6 preprogram zeros", v, 0);
    wait_idle();
    check(last_run == TP + TE, "R10 busy length one sector", last_run, TP + TE);
    for (int w = 0; w < WORDS; w++) begin
      int e;
      rd(12'(w), v);
      e = (w / WPS == 1) ? 255 : init_val(w);
      check(v == e, (w / WPS == 1) ? "R2 erased word" : "R7 untouched word", v, e);
    end

    // R5 multiple sectors, add on the expiry edge
    do_reset(); saw_busy = 0;
    unlock5();
    wr(12'h018, 8'h30);
    idle(10);
    wr(12'h001, 8'h30);
    idle(TT - 1);
    wr(12'h012, 8'h30);
    check(!saw_busy, "R5 add on expiry edge blocked start", int'(saw_busy), 0);
    wait_busy(n);
    check(n == TT, "R5 window restarted", n, TT);
    idle(TP);
    rd(12'h002, v);
    check(v == 0, "R6 lowest sector first", v, 0);
    rd(12'h012, v);
    check(v == init_val(18), "R6 later sector still old", v, init_val(18));
    wait_idle();
    check(last_run == 3 * (TP + TE), "R5 busy length three sectors", last_run, 3 * (TP + TE));
    rd(12'h00A, v);
    check(v == init_val(10), "R7 sector 1 untouched", v, init_val(10));
    rd(12'h003, v); check(v == 255, "R2 sector 0 erased", v, 255);
    rd(12'h015, v); check(v == 255, "R2 sector 2 erased", v, 255);
    rd(12'h01F, v); check(v == 255, "R2 sector 3 erased", v, 255);

    // R8 abort in window
    do_reset(); saw_busy = 0;
    unlock5();
    wr(12'h010, 8'h30);
    idle(5);
    wr(12'h000, 8'hF0);
    wr(12'h013, 8'h30);
    idle(TT + 10);
    check(!saw_busy, "R8 abort prevented erase", int'(saw_busy), 0);
    rd(12'h010, v);
    check(v == init_val(16), "R8 sector 2 unchanged", v, init_val(16));

    // R1 whole array, R9 writes ignored while busy
    do_reset();
    unlock5();
    wr(12'h555, 8'h10);
    check(busy == 1'b1, "R1 busy after chip command", int'(busy), 1);
    unlock5();
    wr(12'h000, 8'h30);
    wait_idle();
    check(last_run == NS * (TP + TE), "R1 chip busy length", last_run, NS * (TP + TE));
    saw_busy = 0;
    idle(TT + 10);
    check(!saw_busy, "R9 writes during busy ignored", int'(saw_busy), 0);
    for (int w = 0; w < WORDS; w += 5) begin
      rd(12'(w), v);
      check(v == 255, "R1 word erased", v, 255);
    end

    // R10 new command accepted after an erase
    unlock5();
    wr(12'h009, 8'h30);
    wait_busy(n);
    check(n == TT, "R10 command after erase", n, TT);
    wait_idle();

    summary();
    $finish;
  end
endmodule